// File: doc/BRIEF.md
# Page-Fault Error Code and Fault-Address Capture

This block sits behind the address-translation logic of a processor core. When the translation path flags an access as faulting, it raises a one-cycle fault strobe and presents the access's linear address and attributes. The attributes are protection versus not-present, write versus read, user versus supervisor, reserved-bit violation and instruction fetch. On that strobe the block assembles the 32-bit page-fault error code that the exception logic pushes for the handler. It also loads the fault-address register with the linear address.

Whether two of the error bits can be reported depends on the paging-mode enables. The reserved-bit flag needs either the large-page enable or the extended-addressing enable. The fetch flag needs the execute-disable enable. Every fault overwrites the fault-address register, so a fault taken while an earlier one is still being delivered, including during double-fault delivery, leaves the newer address. Software can also write the fault-address register through a simple write port.

Top module: `pfr_capture`

## Requirements
- R1: Error code bit 0 is 1 for a protection-violation fault (`acc_prot`=1) and 0 for a not-present fault.
- R2: Error code bit 1 is 1 for a faulting write and 0 for a faulting read.
- R3: Error code bit 2 is 1 for a user-mode access and 0 for a supervisor-mode access.
- R4: Error code bit 3 is 1 only when `acc_rsvd`=1 and at least one of `en_large_page` or `en_ext_addr` is 1; otherwise it is 0.
- R5: Error code bit 4 is 1 only when `acc_fetch`=1 and `en_nx`=1; otherwise it is 0.
- R6: Error code bits 31 to 5 are always 0.
- R7: On the clock edge that samples `flt_stb`=1, `err_code` and `fault_addr` take the new values, and `err_valid` is 1 for exactly the following cycle.
- R8: Each strobe overwrites the fault-address register, including strobes on back-to-back cycles, so the latest fault's address is kept.
- R9: Between strobes, `err_code` holds its value. Without a strobe or a software write, `fault_addr` also holds its value.
- R10: A software write (`sw_wr`=1) without a strobe loads `fault_addr` with `sw_wdata` and leaves `err_code` and `err_valid` unchanged. When a strobe arrives in the same cycle, the fault address is loaded instead.
- R11: A synchronous reset (`rst`=1) clears `err_code`, `err_valid` and `fault_addr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flt_stb | input | 1 | Faulting-access strobe |
| flt_lin_addr | input | 32 | Linear address of the faulting access |
| acc_prot | input | 1 | 1 = protection violation, 0 = page not present |
| acc_write | input | 1 | 1 = write access, 0 = read |
| acc_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| acc_rsvd | input | 1 | Reserved bit found set in a paging entry |
| acc_fetch | input | 1 | Access was an instruction fetch |
| en_large_page | input | 1 | Large-page paging enable |
| en_ext_addr | input | 1 | Extended physical addressing enable |
| en_nx | input | 1 | Execute-disable enable |
| sw_wr | input | 1 | Software write of the fault-address register |
| sw_wdata | input | 32 | Software write data |
| err_code | output | 32 | Latest page-fault error code |
| err_valid | output | 1 | One-cycle pulse with a new error code |
| fault_addr | output | 32 | Fault-address register |

## Verification
On every cycle, the assertions check these properties:
- the reserved upper bits stay zero;
- the valid pulse follows each strobe and only a strobe;
- the address register loads from the strobe or the write port with the strobe taking priority, and holds otherwise;
- the reserved-bit and fetch flags stay clear whenever their enables were off.

The bench scenarios are needed to show the remaining behaviour:
- that each attribute lands in its correct bit with its correct polarity;
- that back-to-back faults leave the newer address;
- that a software write leaves the error code untouched;
- that reset clears all state in the middle of use.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  // Error-code bit positions decoded by the exception handler
  localparam int unsigned BIT_PROT  = 0;
  localparam int unsigned BIT_WRITE = 1;
  localparam int unsigned BIT_USER  = 2;
  localparam int unsigned BIT_RSVD  = 3;
  localparam int unsigned BIT_FETCH = 4;
  localparam int unsigned DEF_BITS  = 5;

  typedef struct packed {
    logic fetch;
    logic rsvd;
    logic user;
    logic write;
    logic prot;
  } pf_attr_t;

  typedef struct packed {
    logic nx_en;
    logic ext_addr;
    logic large_pg;
  } pf_mode_t;

  // Defined (low) bits of the error code, gated by paging mode
  function automatic logic [DEF_BITS-1:0] pf_low_bits(input pf_attr_t a,
                                                      input pf_mode_t m);
    logic [DEF_BITS-1:0] b;
    b            = '0;
    b[BIT_PROT]  = a.prot;
    b[BIT_WRITE] = a.write;
    b[BIT_USER]  = a.user;
    b[BIT_RSVD]  = a.rsvd & (m.large_pg | m.ext_addr);
    b[BIT_FETCH] = a.fetch & m.nx_en;
    return b;
  endfunction

endpackage

// File: rtl/pfr_code_build.sv
module pfr_code_build
  import pfr_pkg::*;
#(
  parameter int unsigned CODE_W = 32
) (
  input  pf_attr_t          attr,
  input  pf_mode_t          mode,
  output logic [CODE_W-1:0] code
);

  localparam int unsigned RES_W = CODE_W - DEF_BITS;

  logic [DEF_BITS-1:0] low_bits;
  assign low_bits = pf_low_bits(attr, mode);

  generate
    if (RES_W > 0) begin : g_pad
      assign code = {{RES_W{1'b0}}, low_bits};
    end else begin : g_nopad
      assign code = low_bits[CODE_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/pfr_code_reg.sv
module pfr_code_reg #(
  parameter int unsigned CODE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q,
  output logic              valid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) code_q <= code_in;
    end
  end

  a_r7_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    load |=> valid_q);

  a_r7_no_valid_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !load |=> !valid_q);

  a_r9_code_holds: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(code_q));

endmodule

// File: rtl/pfr_addr_reg.sv
module pfr_addr_reg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_ld,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic              sw_ld,
  input  logic [ADDR_W-1:0] sw_data,
  output logic [ADDR_W-1:0] addr_q
);

  // Named load events; the fault path outranks the software write
  logic take_flt;
  logic take_sw;
  assign take_flt = flt_ld;
  assign take_sw  = sw_ld & ~flt_ld;

  always_ff @(posedge clk) begin
    if (rst)           addr_q <= '0;
    else if (take_flt) addr_q <= flt_addr;
    else if (take_sw)  addr_q <= sw_data;
  end

  a_r8_fault_loads_addr: assert property (@(posedge clk) disable iff (rst)
    flt_ld |=> addr_q == $past(flt_addr));

  a_r10_sw_loads_addr: assert property (@(posedge clk) disable iff (rst)
    (sw_ld && !flt_ld) |=> addr_q == $past(sw_data));

  a_r9_addr_holds: assert property (@(posedge clk) disable iff (rst)
    (!flt_ld && !sw_ld) |=> $stable(addr_q));

  a_r10_single_source: assert property (@(posedge clk) disable iff (rst)
    $countones({take_flt, take_sw}) <= 1);

endmodule

// File: rtl/pfr_capture.sv
module pfr_capture
  import pfr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CODE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_stb,
  input  logic [ADDR_W-1:0] flt_lin_addr,
  input  logic              acc_prot,
  input  logic              acc_write,
  input  logic              acc_user,
  input  logic              acc_rsvd,
  input  logic              acc_fetch,
  input  logic              en_large_page,
  input  logic              en_ext_addr,
  input  logic              en_nx,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_wdata,
  output logic [CODE_W-1:0] err_code,
  output logic              err_valid,
  output logic [ADDR_W-1:0] fault_addr
);

  pf_attr_t          attr;
  pf_mode_t          mode;
  logic [CODE_W-1:0] code_next;

  assign attr = '{fetch: acc_fetch, rsvd: acc_rsvd, user: acc_user,
                  write: acc_write, prot: acc_prot};
  assign mode = '{nx_en: en_nx, ext_addr: en_ext_addr, large_pg: en_large_page};

  pfr_code_build #(.CODE_W(CODE_W)) u_build (
    .attr (attr),
    .mode (mode),
    .code (code_next)
  );

  pfr_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk     (clk),
    .rst     (rst),
    .load    (flt_stb),
    .code_in (code_next),
    .code_q  (err_code),
    .valid_q (err_valid)
  );

  pfr_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .flt_ld   (flt_stb),
    .flt_addr (flt_lin_addr),
    .sw_ld    (sw_wr),
    .sw_data  (sw_wdata),
    .addr_q   (fault_addr)
  );

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    err_code[CODE_W-1:DEF_BITS] == '0);

  a_r4_rsvd_gated: assert property (@(posedge clk) disable iff (rst)
    (flt_stb && !en_large_page && !en_ext_addr) |=> !err_code[BIT_RSVD]);

  a_r5_fetch_gated: assert property (@(posedge clk) disable iff (rst)
    (flt_stb && !en_nx) |=> !err_code[BIT_FETCH]);

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (err_code == '0 && !err_valid && fault_addr == '0));

endmodule

// File: tb/sim_pfr_capture.sv
`timescale 1ns/1ps
module sim_pfr_capture;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flt_stb = 1'b0;
  logic [31:0] flt_lin_addr = '0;
  logic        acc_prot = 1'b0, acc_write = 1'b0, acc_user = 1'b0;
  logic        acc_rsvd = 1'b0, acc_fetch = 1'b0;
  logic        en_large_page = 1'b0, en_ext_addr = 1'b0, en_nx = 1'b0;
  logic        sw_wr = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] err_code;
  logic        err_valid;
  logic [31:0] fault_addr;

  always #5 clk = ~clk;

  pfr_capture u0 (
    .clk(clk), .rst(rst), .flt_stb(flt_stb), .flt_lin_addr(flt_lin_addr),
    .acc_prot(acc_prot), .acc_write(acc_write), .acc_user(acc_user),
    .acc_rsvd(acc_rsvd), .acc_fetch(acc_fetch),
    .en_large_page(en_large_page), .en_ext_addr(en_ext_addr), .en_nx(en_nx),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .err_code(err_code), .err_valid(err_valid), .fault_addr(fault_addr)
  );

  int checks = 0;
  int errors = 0;

  // Scoreboard
  logic [31:0] q_code[$];
  logic [31:0] q_addr[$];
  logic        q_vld[$];
  string       q_tag[$];

  // Reference state
  logic [31:0] m_code = '0;
  logic [31:0] m_addr = '0;

  function automatic logic [31:0] ref_code(input logic [4:0] f, input logic [2:0] m);
    // f = {fetch,rsvd,user,write,prot}, m = {nx,ext,large}
    logic [31:0] c = 32'h0;
    if (f[0]) c = c + 32'h1;
    if (f[1]) c = c + 32'h2;
    if (f[2]) c = c + 32'h4;
    if (f[3] && (m[0] || m[1])) c = c + 32'h8;
    if (f[4] && m[2]) c = c + 32'h10;
    return c;
  endfunction

  task automatic push(input logic v, input string tag);
    q_code.push_back(m_code);
    q_addr.push_back(m_addr);
    q_vld.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic step(input logic stb, input logic [31:0] a, input logic [4:0] f,
                      input logic [2:0] m, input logic sw, input logic [31:0] swd,
                      input string tag);
    @(negedge clk);
    rst = 1'b0;
    flt_stb = stb; flt_lin_addr = a;
    {acc_fetch, acc_rsvd, acc_user, acc_write, acc_prot} = f;
    {en_nx, en_ext_addr, en_large_page} = m;
    sw_wr = sw; sw_wdata = swd;
    if (stb) begin
      m_code = ref_code(f, m);
      m_addr = a;
    end else if (sw) begin
      m_addr = swd;
    end
    push(stb, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; flt_stb = 1'b0; sw_wr = 1'b0;
    flt_lin_addr = 32'hFFFF_FFFF; sw_wdata = 32'hFFFF_FFFF;
    m_code = '0; m_addr = '0;
    push(1'b0, tag);
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_tag.size() > 0) begin
        logic [31:0] ec, ea;
        logic        ev;
        string       t;
        ec = q_code.pop_front(); ea = q_addr.pop_front();
        ev = q_vld.pop_front();  t  = q_tag.pop_front();
        checks += 3;
        if (err_code !== ec) begin
          errors++;
          $display("FAIL %s err_code actual=%h expected=%h", t, err_code, ec);
        end
        if (fault_addr !== ea) begin
          errors++;
          $display("FAIL %s fault_addr actual=%h expected=%h", t, fault_addr, ea);
        end
        if (err_valid !== ev) begin
          errors++;
          $display("FAIL %s err_valid actual=%b expected=%b", t, err_valid, ev);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset("R11 initial reset");
    do_reset("R11 reset held");
    step(0, 32'h0, 5'b0, 3'b0, 0, 32'h0, "R9 idle after reset");
    step(1, 32'h1000_0ABC, 5'b00000, 3'b000, 0, 32'h0, "R1 R7 not-present read supervisor");
    step(0, 32'h0, 5'b11111, 3'b111, 0, 32'h0, "R7 R9 pulse ends and values hold");
    step(1, 32'h2000_1004, 5'b00111, 3'b000, 0, 32'h0, "R1 R2 R3 protection write user");
    step(1, 32'h2000_2008, 5'b00010, 3'b000, 0, 32'h0, "R2 write only");
    step(1, 32'h2000_3000, 5'b00100, 3'b000, 0, 32'h0, "R3 user read");
    step(1, 32'h3000_0000, 5'b01000, 3'b000, 0, 32'h0, "R4 rsvd masked when modes off");
    step(1, 32'h3000_1000, 5'b01000, 3'b001, 0, 32'h0, "R4 rsvd with large-page");
    step(1, 32'h3000_2000, 5'b01000, 3'b010, 0, 32'h0, "R4 rsvd with ext-addr");
    step(1, 32'h3000_3000, 5'b01000, 3'b100, 0, 32'h0, "R4 rsvd with only nx enabled");
    step(1, 32'h4000_0000, 5'b10000, 3'b011, 0, 32'h0, "R5 fetch masked when nx off");
    step(1, 32'h4000_1000, 5'b10000, 3'b100, 0, 32'h0, "R5 fetch with nx");
    step(1, 32'hFFFF_FFFF, 5'b11111, 3'b111, 0, 32'h0, "R6 all flags upper bits zero");
    step(1, 32'h5000_0001, 5'b00001, 3'b000, 0, 32'h0, "R8 first of nested faults");
    step(1, 32'h5000_0002, 5'b00010, 3'b000, 0, 32'h0, "R8 second fault overwrites");
    step(0, 32'h0, 5'b0, 3'b0, 0, 32'h0, "R8 R9 newer address kept");
    step(0, 32'h0, 5'b11111, 3'b111, 1, 32'h6666_7777, "R10 software write alone");
    step(0, 32'h0, 5'b0, 3'b0, 0, 32'h0, "R10 R9 software value holds");
    step(1, 32'h7000_0010, 5'b00101, 3'b000, 1, 32'h8888_9999, "R10 strobe beats software write");
    do_reset("R11 reset mid-use");
    step(0, 32'h0, 5'b0, 3'b0, 0, 32'h0, "R11 R9 cleared state holds");
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r = $urandom;
      step(r[0], $urandom, r[5:1], r[8:6], r[9], $urandom, "R7 R8 R10 mixed traffic");
    end
    @(negedge clk);
    flt_stb = 1'b0; sw_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule